// File: doc/BRIEF.md
# Three-Phase Gate Command Interlock with Dead Time

This block sits between a PWM generator and the gate drivers of a three-phase bridge. Each of the six power switches has its own command bit. The high-side command bits are active-low, so one wire per phase can be tied to both the high and the low bit of that phase and still give complementary switching. Each command bit goes through a two-flop synchronizer. A state machine per phase then turns the requests into six gate-on outputs.

A programmable gap separates one switch of a phase turning off from its partner turning on. The gap is `dtCount + MIN_DT` clock cycles, so a setting of zero still gives the smallest legal gap. The gap is counted from the moment the previous device actually turned off. A skew between the two edges of a phase that is shorter than the gap therefore changes nothing at the outputs. A reversal that lasts less than the gap only turns the active device off for a short time; its partner is never turned on. A request for both switches of a phase is ignored and the state is frozen. A low enable forces every output off at once.

Top module: `gate_interlock`

## Requirements
- R1: Bit p of `cmd` (p = 0..2) requests the low-side switch of phase p and is active-high. Bit 3+p requests the high-side switch and is active-low. `gateOn[p]` drives the low side and `gateOn[3+p]` the high side. From an idle phase, a single request turns its output on on the fourth rising edge after the input change: two synchronizer edges, one edge into the waiting state, and one edge into the on state.
- R2: When a phase's high and low bits are driven from one shared line, line low selects the high side and line high selects the low side.
- R3: When a phase moves from one switch to its partner, the partner turns on exactly D = dtCount + MIN_DT cycles after the other switch turned off. The gap is the same in both directions.
- R4: A `dtCount` of 0 gives a gap of MIN_DT (default 2) cycles.
- R5: A request for both switches of one phase leaves that phase's outputs in their previous state, whether that state is high on, low on, or both off.
- R6: When the high-side release and the low-side request of a phase are skewed by fewer than D cycles, the low side still turns on D cycles after the high side turned off, the same as for a simultaneous change.
- R7: A request for the partner that lasts less than D cycles turns the active switch off. The partner never turns on, and the original switch comes back D cycles after it turned off.
- R8: While `enable` is low, all six outputs are off in the same cycle. Once `enable` returns high, each phase starts again from the both-off state.
- R9: The two switches of one phase are never on at the same time.
- R10: The three phases are independent. Activity on one phase does not change the outputs of another.
- R11: During reset and after reset, all outputs are off until a request has passed through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; low forces all gates off |
| cmd | input | 6 | [2:0] low-side requests (active-high), [5:3] high-side requests (active-low) |
| dtCount | input | DT_W | Dead-time setting; gap = dtCount + MIN_DT cycles |
| gateOn | output | 6 | [2:0] low-side gate on, [5:3] high-side gate on |

## Verification
The gap countdown ending and a change of the request for the same phase can fall on the same clock edge. The block must then choose between finishing the transition and reversing it. The short-pulse test creates this case by flipping the phase back while the countdown is still running. The skew test staggers the release and the new request so that the request arrives partway through the countdown. In both tests the bench samples every cycle that the partner never turns on, and that the on-edge arrives exactly D cycles after the turn-off edge.

// File: rtl/gate_interlock_pkg.sv
package gate_interlock_pkg;
  localparam int NUM_PH = 3;
  localparam int CMD_W = 2 * NUM_PH;

  typedef enum logic [2:0] {
    BOTH_OFF,
    WAIT_HS,
    HS_ON,
    WAIT_LS,
    LS_ON
  } legState_e;

  // Strobes from the phase controllers to the datapath
  typedef struct packed {
    logic [NUM_PH-1:0] loadGap;
    logic [NUM_PH-1:0] hiOn;
    logic [NUM_PH-1:0] loOn;
  } ctrlStrobe_t;
endpackage

// File: rtl/gi_datapath.sv
module gi_datapath
  import gate_interlock_pkg::*;
#(
  parameter int DT_W        = 6,
  parameter int MIN_DT      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DT_W-1:0]   dtCount,
  input  ctrlStrobe_t       strobe,
  output logic [NUM_PH-1:0] hiReq,
  output logic [NUM_PH-1:0] loReq,
  output logic [NUM_PH-1:0] gapZero,
  output logic [CMD_W-1:0]  gateOn
);
  localparam int CNT_W = DT_W + 1;
  localparam logic [CMD_W-1:0] IDLE_CMD = {{NUM_PH{1'b1}}, {NUM_PH{1'b0}}};

  logic [CMD_W-1:0] syncQ [SYNC_STAGES];
  logic [CNT_W-1:0] loadVal;

  // Synchronizer chain; resets to the "nothing requested" pattern
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= IDLE_CMD;
    end else begin
      syncQ[0] <= cmd;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign loReq   = syncQ[SYNC_STAGES-1][NUM_PH-1:0];
  assign hiReq   = ~syncQ[SYNC_STAGES-1][CMD_W-1:NUM_PH];
  assign loadVal = CNT_W'(dtCount) + CNT_W'(MIN_DT - 1);

  // Combinational gating so a low enable takes effect in the same cycle
  assign gateOn = enable ? {strobe.hiOn, strobe.loOn} : '0;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_gap
    logic [CNT_W-1:0] gap;

    // Counts the cycles since this phase last turned a device off
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  gap <= '0;
      else if (strobe.loadGap[p]) gap <= loadVal;
      else if (gap != '0)         gap <= gap - 1'b1;
    end

    assign gapZero[p] = (gap == '0);

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rstN)
      !(gateOn[p] && gateOn[NUM_PH+p])); // R9
    AST_GAP_BEFORE_HS: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateOn[NUM_PH+p]) |-> !$past(gateOn[p])); // R3
    AST_GAP_BEFORE_LS: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateOn[p]) |-> !$past(gateOn[NUM_PH+p])); // R3
  end
endmodule

// File: rtl/gi_control.sv
module gi_control
  import gate_interlock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [NUM_PH-1:0] hiReq,
  input  logic [NUM_PH-1:0] loReq,
  input  logic [NUM_PH-1:0] gapZero,
  output ctrlStrobe_t       strobe
);
  logic [NUM_PH-1:0] loadV;
  logic [NUM_PH-1:0] hiOnV;
  logic [NUM_PH-1:0] loOnV;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    legState_e st;
    legState_e nxt;
    logic      ld;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) st <= BOTH_OFF;
      else       st <= nxt;
    end

    always_comb begin
      nxt = st;
      ld  = 1'b0;
      if (!enable) begin
        nxt = BOTH_OFF;
        ld  = (st == HS_ON) || (st == LS_ON);
      end else if (hiReq[p] && loReq[p]) begin
        nxt = st;                       // conflicting request: freeze
      end else begin
        case (st)
          BOTH_OFF: begin
            if (hiReq[p])      nxt = WAIT_HS;
            else if (loReq[p]) nxt = WAIT_LS;
          end
          WAIT_HS: begin
            if (hiReq[p])      nxt = gapZero[p] ? HS_ON : WAIT_HS;
            else if (loReq[p]) nxt = WAIT_LS;
            else               nxt = BOTH_OFF;
          end
          HS_ON: begin
            if (!hiReq[p]) begin
              ld  = 1'b1;
              nxt = loReq[p] ? WAIT_LS : BOTH_OFF;
            end
          end
          WAIT_LS: begin
            if (loReq[p])      nxt = gapZero[p] ? LS_ON : WAIT_LS;
            else if (hiReq[p]) nxt = WAIT_HS;
            else               nxt = BOTH_OFF;
          end
          LS_ON: begin
            if (!loReq[p]) begin
              ld  = 1'b1;
              nxt = hiReq[p] ? WAIT_HS : BOTH_OFF;
            end
          end
          default: nxt = BOTH_OFF;
        endcase
      end
    end

    assign loadV[p] = ld;
    assign hiOnV[p] = (st == HS_ON);
    assign loOnV[p] = (st == LS_ON);

    AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      enable && hiReq[p] && loReq[p] |=> st == $past(st)); // R5
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
      !enable |=> st == BOTH_OFF); // R8
  end

  assign strobe = '{loadGap: loadV, hiOn: hiOnV, loOn: loOnV};
endmodule

// File: rtl/gate_interlock.sv
module gate_interlock
  import gate_interlock_pkg::*;
#(
  parameter int DT_W        = 6,
  parameter int MIN_DT      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CMD_W-1:0] cmd,
  input  logic [DT_W-1:0]  dtCount,
  output logic [CMD_W-1:0] gateOn
);
  ctrlStrobe_t       strobe;
  logic [NUM_PH-1:0] hiReq;
  logic [NUM_PH-1:0] loReq;
  logic [NUM_PH-1:0] gapZero;

  gi_datapath #(
    .DT_W(DT_W), .MIN_DT(MIN_DT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .cmd(cmd), .dtCount(dtCount),
    .strobe(strobe), .hiReq(hiReq), .loReq(loReq), .gapZero(gapZero),
    .gateOn(gateOn)
  );

  gi_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .hiReq(hiReq), .loReq(loReq),
    .gapZero(gapZero), .strobe(strobe)
  );
endmodule

// File: tb/gate_interlock_tb.sv
`timescale 1ns/1ps
module gate_interlock_tb;
  localparam int DT_W = 6;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            enable = 1'b0;
  logic [5:0]      cmd = 6'b111000;
  logic [DT_W-1:0] dtCount = '0;
  logic [5:0]      gateOn;

  int errors = 0;
  int checks = 0;
  int overlap = 0;

  always #2.5 clk = ~clk;

  gate_interlock #(.DT_W(DT_W), .MIN_DT(2), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cmd(cmd),
    .dtCount(dtCount), .gateOn(gateOn)
  );

  always @(negedge clk)
    if (rstN)
      for (int p = 0; p < 3; p++)
        if (gateOn[p] && gateOn[3+p]) overlap++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic hiG(input int p); return gateOn[3+p]; endfunction
  function automatic logic loG(input int p); return gateOn[p];   endfunction

  task automatic tiedLine(input int p, input logic v);
    cmd[p] = v; cmd[3+p] = v;
  endtask

  task automatic goIdle();
    cmd = 6'b111000;
    tick(12);
  endtask

  task automatic holdHigh(input int p);
    tiedLine(p, 1'b0);
    cmd[p] = 1'b0;
    tick(10);
  endtask

  // R1 R2 R3: tied line, gap in both directions
  task automatic testTiedLine();
    dtCount = 3;                    // D = 5
    tiedLine(0, 1'b0);
    tick(3); chk("R1 hs still waiting", hiG(0), 1'b0);
    tick(1); chk("R1 hs on at 4th edge", hiG(0), 1'b1);
    chk("R2 ls off with line low", loG(0), 1'b0);
    tick(8);
    tiedLine(0, 1'b1);
    tick(3); chk("R2 hs off with line high", hiG(0), 1'b0);
    tick(4); chk("R3 ls off before gap", loG(0), 1'b0);
    tick(1); chk("R3 ls on after gap", loG(0), 1'b1);
    tiedLine(0, 1'b0);
    tick(3); chk("R3 ls off", loG(0), 1'b0);
    tick(4); chk("R3 hs off before gap", hiG(0), 1'b0);
    tick(1); chk("R3 hs on after gap", hiG(0), 1'b1);
    goIdle();
  endtask

  // R4: zero setting gives MIN_DT
  task automatic testMinDt();
    dtCount = 0;                    // D = 2
    tiedLine(0, 1'b0);
    tick(12);
    tiedLine(0, 1'b1);
    tick(3); chk("R4 hs off", hiG(0), 1'b0);
    tick(1); chk("R4 ls off at 1 cycle", loG(0), 1'b0);
    tick(1); chk("R4 ls on at 2 cycles", loG(0), 1'b1);
    goIdle();
  endtask

  // R5: conflicting request freezes state
  task automatic testConflict();
    bit okHs = 1'b1;
    bit okLs = 1'b1;
    bit okOff = 1'b1;
    dtCount = 3;
    holdHigh(0);
    chk("R5 hs on before conflict", hiG(0), 1'b1);
    cmd[0] = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (!(hiG(0) && !loG(0))) okHs = 1'b0;
    end
    chk("R5 hs held during conflict", okHs, 1'b1);
    cmd[3] = 1'b1;
    tick(3); chk("R5 hs released", hiG(0), 1'b0);
    tick(5); chk("R5 ls on after release", loG(0), 1'b1);
    cmd[3] = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (!(loG(0) && !hiG(0))) okLs = 1'b0;
    end
    chk("R5 ls held during conflict", okLs, 1'b1);
    goIdle();
    cmd[0] = 1'b1; cmd[3] = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (hiG(0) || loG(0)) okOff = 1'b0;
    end
    chk("R5 off held during conflict", okOff, 1'b1);
    goIdle();
  endtask

  // R6: skew shorter than gap
  task automatic testSkew();
    dtCount = 3;
    holdHigh(0);
    cmd[3] = 1'b1;
    tick(2);
    cmd[0] = 1'b1;
    tick(1); chk("R6 hs off", hiG(0), 1'b0);
    tick(4); chk("R6 ls off before gap", loG(0), 1'b0);
    tick(1); chk("R6 ls on gap from hs off", loG(0), 1'b1);
    goIdle();
  endtask

  // R7: reversal shorter than gap
  task automatic testShortPulse();
    bit partnerOn = 1'b0;
    bit hsEarly = 1'b0;
    dtCount = 3;
    tiedLine(0, 1'b0);
    tick(12);
    tiedLine(0, 1'b1);
    tick(2);
    tiedLine(0, 1'b0);
    for (int e = 3; e <= 7; e++) begin
      tick(1);
      if (loG(0)) partnerOn = 1'b1;
      if (hiG(0)) hsEarly = 1'b1;
    end
    chk("R7 partner never on", partnerOn, 1'b0);
    chk("R7 hs off during pulse", hsEarly, 1'b0);
    tick(1); chk("R7 hs back after gap", hiG(0), 1'b1);
    goIdle();
  endtask

  // R8: enable forces off
  task automatic testEnable();
    bit stayOff = 1'b1;
    dtCount = 3;
    tiedLine(0, 1'b0);
    tiedLine(1, 1'b1);
    tick(12);
    chk("R8 hs0 on before disable", hiG(0), 1'b1);
    enable = 1'b0;
    #1 chk("R8 all off same cycle", (gateOn == 6'b0), 1'b1);
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (gateOn != 6'b0) stayOff = 1'b0;
    end
    chk("R8 all off while disabled", stayOff, 1'b1);
    enable = 1'b1;
    tick(1); chk("R8 restart from off", hiG(0) || loG(1), 1'b0);
    tick(1);
    chk("R8 hs0 back", hiG(0), 1'b1);
    chk("R8 ls1 back", loG(1), 1'b1);
    goIdle();
  endtask

  // R10: phases independent
  task automatic testIndependent();
    bit p2Steady = 1'b1;
    bit p0Quiet = 1'b1;
    dtCount = 3;
    tiedLine(1, 1'b0);
    tiedLine(2, 1'b1);
    tick(12);
    tiedLine(1, 1'b1);
    for (int e = 1; e <= 7; e++) begin
      tick(1);
      if (!loG(2) || hiG(2)) p2Steady = 1'b0;
      if (gateOn[0] || gateOn[3]) p0Quiet = 1'b0;
    end
    tick(1); chk("R10 phase1 ls on after gap", loG(1), 1'b1);
    chk("R10 phase2 unchanged", p2Steady, 1'b1);
    chk("R10 phase0 untouched", p0Quiet, 1'b1);
    goIdle();
  endtask

  initial begin
    enable = 1'b1;
    dtCount = 3;
    repeat (3) @(negedge clk);
    chk("R11 off in reset", (gateOn == 6'b0), 1'b1);
    rstN = 1'b1;
    tick(5);
    chk("R11 off after reset", (gateOn == 6'b0), 1'b1);
    testTiedLine();
    testMinDt();
    testConflict();
    testSkew();
    testShortPulse();
    testEnable();
    testIndependent();
    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R9 overlap cycles: actual=%0d expected=0", overlap);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule